// File: doc/BRIEF.md
# Data Lane High-Speed Entry and Exit Sequencer

This block drives the control side of one transmit data lane, clocked by the byte clock. Between bursts it holds the lane in the LP-11 stop state. When a burst is requested it walks the line through LP-01 and then LP-00. It then turns on the high-speed driver and sends an all-zero preamble followed by a single sync byte. Next it streams the caller's bytes under a valid/ready handshake. When the payload ends it drives a trail pattern, returns to LP-11 and enforces a recovery interval before the next burst may begin.

Each timed state lasts for a number of byte clocks taken from its own configuration input. A count of zero is treated as one, so no state can collapse to nothing, whatever value is programmed. A request that arrives while the lane is recovering after a burst is remembered and acted on as soon as recovery ends. A request that arrives at any other point of a burst is dropped. The configuration inputs are expected to change only while the lane is idle.

Top module: `dlane_sot_seq`

States and transitions: IDLE goes to LP01 on a request or a held request. LP01 goes to LP00, LP00 to PREP and PREP to ZERO, each when its dwell expires. ZERO goes to SYNC when its dwell expires. SYNC goes to PAY after one cycle. PAY goes to TRAIL on the first cycle without valid. TRAIL goes to EXIT and EXIT goes to IDLE, each when its dwell expires.

## Requirements
- R1: During and right after reset the lane shows LP-11 (lp_dp=1, lp_dn=1), with hs_en=0 and tx_ready=0.
- R2: A tx_req sampled while idle makes the lane show LP-01 (lp_dp=0, lp_dn=1) from the next cycle for max(cfg_lpstate,1) cycles, then LP-00 (both 0) for max(cfg_lpstate,1) cycles.
- R3: After LP-00, hs_en is 1, the LP pair is 00 and hs_data is 0x00 for max(cfg_hsprep,1)+max(cfg_hszero,1) cycles.
- R4: A configuration value of zero gives a dwell of exactly one cycle in every timed state.
- R5: The cycle right after the zero preamble carries hs_data=0xB8 with hs_en=1, for exactly one cycle.
- R6: From the cycle after the sync byte, tx_ready is 1. In every such cycle with tx_valid=1, hs_data equals tx_data and the byte counts as sent. Bytes go out least significant bit first.
- R7: The first ready cycle without tx_valid starts the trail. hs_en stays 1 and hs_data repeats the inverse of bit 7 of the last byte sent (of the sync byte if no payload byte was sent) for 1+max(cfg_hstrail,1) cycles. tx_ready is 1 only in the first of these cycles.
- R8: After the trail the lane shows LP-11 with hs_en=0 for max(cfg_lpexit,1) cycles, plus at least one idle cycle, before any new LP-01.
- R9: A tx_req sampled in any cycle of the post-burst LP-11 interval is held. The entry sequence then starts after exactly one idle cycle, without a further request.
- R10: A tx_req sampled from LP-01 through the end of the trail has no effect: after that burst the lane stays in LP-11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Request for one high-speed burst |
| tx_valid | input | 1 | Payload byte present on tx_data |
| tx_data | input | 8 | Payload byte |
| cfg_lpstate | input | CW | Dwell of LP-01 and of LP-00, in byte clocks |
| cfg_hsprep | input | CW | Dwell of the HS prepare part, in byte clocks |
| cfg_hszero | input | CW | Dwell of the HS zero preamble, in byte clocks |
| cfg_hstrail | input | CW | Dwell of the trail after the payload, in byte clocks |
| cfg_lpexit | input | CW | Dwell of LP-11 recovery after a burst, in byte clocks |
| tx_ready | output | 1 | Payload byte accepted when tx_valid is also 1 |
| lp_dp | output | 1 | Low-power level for the positive line |
| lp_dn | output | 1 | Low-power level for the negative line |
| hs_en | output | 1 | High-speed driver enable |
| hs_data | output | 8 | Byte handed to the serialiser |

## Verification
Two functions can meet in one cycle: the end of the recovery interval and the capture of a new request. The bench raises tx_req in the last recovery cycle. It then expects exactly one LP-11 idle cycle followed by a complete entry sequence with correct dwells, and repeats the same test with the request in the first recovery cycle. A second overlap comes from stray requests during the entry states and during the payload. These requests fall in the same cycles in which payload bytes are taken and the trail begins. The bench judges them by checking that the lane stays in LP-11 once that burst is over.

// File: rtl/dlane_pkg.sv
package dlane_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hB8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LP01,
        ST_LP00,
        ST_PREP,
        ST_ZERO,
        ST_SYNC,
        ST_PAY,
        ST_TRAIL,
        ST_EXIT
    } lane_st_e;

endpackage

// File: rtl/dlane_dwell_timer.sv
module dlane_dwell_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/dlane_seq_fsm.sv
module dlane_seq_fsm
    import dlane_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_req,
    input  logic          tx_valid,
    input  logic          tmr_done,
    input  logic [CW-1:0] cfg_lpstate,
    input  logic [CW-1:0] cfg_hsprep,
    input  logic [CW-1:0] cfg_hszero,
    input  logic [CW-1:0] cfg_hstrail,
    input  logic [CW-1:0] cfg_lpexit,
    output lane_st_e      state_q,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val
);

    lane_st_e state_d;
    logic     pend_q;

    // A zero count still gives one cycle of dwell
    function automatic logic [CW-1:0] dwell_m1(input logic [CW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tx_req || pend_q) state_d = ST_LP01;
            ST_LP01:  if (tmr_done) state_d = ST_LP00;
            ST_LP00:  if (tmr_done) state_d = ST_PREP;
            ST_PREP:  if (tmr_done) state_d = ST_ZERO;
            ST_ZERO:  if (tmr_done) state_d = ST_SYNC;
            ST_SYNC:  state_d = ST_PAY;
            ST_PAY:   if (!tx_valid) state_d = ST_TRAIL;
            ST_TRAIL: if (tmr_done) state_d = ST_EXIT;
            ST_EXIT:  if (tmr_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Request captured during recovery, released on reaching idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            pend_q <= 1'b0;
        end else if (state_q == ST_EXIT && tx_req) begin
            pend_q <= 1'b1;
        end
    end

    assign tmr_load = (state_d != state_q);

    always_comb begin
        tmr_val = '0;
        unique case (state_d)
            ST_LP01, ST_LP00: tmr_val = dwell_m1(cfg_lpstate);
            ST_PREP:          tmr_val = dwell_m1(cfg_hsprep);
            ST_ZERO:          tmr_val = dwell_m1(cfg_hszero);
            ST_TRAIL:         tmr_val = dwell_m1(cfg_hstrail);
            ST_EXIT:          tmr_val = dwell_m1(cfg_lpexit);
            default:          tmr_val = '0;
        endcase
    end

    a_r2_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && (tx_req || pend_q)) |=> state_q == ST_LP01);

    a_r2_lp01_order: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LP01 |=> (state_q == ST_LP01 || state_q == ST_LP00));

    a_r3_lp00_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LP00 && !tmr_done) |=> state_q == ST_LP00);

    a_r5_zero_to_sync: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_ZERO |=> (state_q == ST_ZERO || state_q == ST_SYNC));

    a_r5_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SYNC |=> state_q == ST_PAY);

    a_r8_exit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXIT && !tmr_done) |=> state_q == ST_EXIT);

    a_r9_pend_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXIT && tx_req) |=> pend_q);

endmodule

// File: rtl/dlane_lane_map.sv
module dlane_lane_map
    import dlane_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  lane_st_e          state_q,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              lp_dp,
    output logic              lp_dn,
    output logic              hs_en,
    output logic [BYTE_W-1:0] hs_data
);

    logic last_bit_q;

    // Bit 7 is the last bit on the wire, since bytes go out LSB first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_bit_q <= 1'b1;
        end else if (state_q == ST_SYNC) begin
            last_bit_q <= SYNC_BYTE[BYTE_W-1];
        end else if (state_q == ST_PAY && tx_valid) begin
            last_bit_q <= tx_data[BYTE_W-1];
        end
    end

    always_comb begin
        lp_dp    = 1'b0;
        lp_dn    = 1'b0;
        hs_en    = 1'b0;
        tx_ready = 1'b0;
        hs_data  = '0;
        unique case (state_q)
            ST_IDLE, ST_EXIT: begin
                lp_dp = 1'b1;
                lp_dn = 1'b1;
            end
            ST_LP01: begin
                lp_dn = 1'b1;
            end
            ST_LP00: begin
            end
            ST_PREP, ST_ZERO: begin
                hs_en = 1'b1;
            end
            ST_SYNC: begin
                hs_en   = 1'b1;
                hs_data = SYNC_BYTE;
            end
            ST_PAY: begin
                hs_en    = 1'b1;
                tx_ready = 1'b1;
                hs_data  = tx_valid ? tx_data : {BYTE_W{~last_bit_q}};
            end
            ST_TRAIL: begin
                hs_en   = 1'b1;
                hs_data = {BYTE_W{~last_bit_q}};
            end
            default: begin
                lp_dp = 1'b1;
                lp_dn = 1'b1;
            end
        endcase
    end

    a_r7_trail_steady: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_TRAIL |=> (state_q == ST_EXIT || $stable(hs_data)));

    a_r7_trail_keeps_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAY && !tx_valid) |=> (hs_en && !tx_ready));

endmodule

// File: rtl/dlane_sot_seq.sv
module dlane_sot_seq
    import dlane_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_req,
    input  logic          tx_valid,
    input  logic [7:0]    tx_data,
    input  logic [CW-1:0] cfg_lpstate,
    input  logic [CW-1:0] cfg_hsprep,
    input  logic [CW-1:0] cfg_hszero,
    input  logic [CW-1:0] cfg_hstrail,
    input  logic [CW-1:0] cfg_lpexit,
    output logic          tx_ready,
    output logic          lp_dp,
    output logic          lp_dn,
    output logic          hs_en,
    output logic [7:0]    hs_data
);

    lane_st_e      state_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;

    dlane_seq_fsm #(.CW(CW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_req      (tx_req),
        .tx_valid    (tx_valid),
        .tmr_done    (tmr_done),
        .cfg_lpstate (cfg_lpstate),
        .cfg_hsprep  (cfg_hsprep),
        .cfg_hszero  (cfg_hszero),
        .cfg_hstrail (cfg_hstrail),
        .cfg_lpexit  (cfg_lpexit),
        .state_q     (state_q),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val)
    );

    dlane_dwell_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    dlane_lane_map u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_q  (state_q),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .lp_dp    (lp_dp),
        .lp_dn    (lp_dn),
        .hs_en    (hs_en),
        .hs_data  (hs_data)
    );

    a_r2_hs_off_in_lp: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_dp || lp_dn) |-> (!hs_en && !tx_ready));

    a_r10_no_start_from_hs: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |=> !(lp_dn && !lp_dp));

endmodule

// File: tb/dlane_sot_seq_tb.sv
module dlane_sot_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_req = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic [7:0] cfg_lpstate = 8'd1;
    logic [7:0] cfg_hsprep = 8'd1;
    logic [7:0] cfg_hszero = 8'd1;
    logic [7:0] cfg_hstrail = 8'd1;
    logic [7:0] cfg_lpexit = 8'd1;
    logic       tx_ready, lp_dp, lp_dn, hs_en;
    logic [7:0] hs_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dlane_sot_seq #(.CW(8)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_req      (tx_req),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .cfg_lpstate (cfg_lpstate),
        .cfg_hsprep  (cfg_hsprep),
        .cfg_hszero  (cfg_hszero),
        .cfg_hstrail (cfg_hstrail),
        .cfg_lpexit  (cfg_lpexit),
        .tx_ready    (tx_ready),
        .lp_dp       (lp_dp),
        .lp_dn       (lp_dn),
        .hs_en       (hs_en),
        .hs_data     (hs_data)
    );

    task automatic step(input logic req, input logic vld, input logic [7:0] d);
        @(negedge clk);
        tx_req   = req;
        tx_valid = vld;
        tx_data  = d;
        #1;
    endtask

    task automatic chk(input string tag, input logic dp, input logic dn, input logic en,
                       input logic rdy, input logic [7:0] dat, input bit use_dat);
        checks++;
        if (lp_dp !== dp || lp_dn !== dn || hs_en !== en || tx_ready !== rdy ||
            (use_dat && hs_data !== dat)) begin
            errors++;
            $display("FAIL %s: got lp=%b%b en=%b rdy=%b data=%h, expected lp=%b%b en=%b rdy=%b data=%h",
                     tag, lp_dp, lp_dn, hs_en, tx_ready, hs_data, dp, dn, en, rdy, dat);
        end
    endtask

    task automatic idle_check(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            step(1'b0, 1'b0, 8'h00);
            chk(tag, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        end
    endtask

    // One full burst; stray_at indexes cycles from the first LP-01 cycle,
    // exit_req_at indexes cycles of the recovery interval
    task automatic burst(input int lpx, input int prep, input int zero, input int trail,
                         input int ex, input int nb, input bit self_req, input int stray_at,
                         input int exit_req_at, input logic [7:0] seed);
        int l = (lpx == 0) ? 1 : lpx;
        int p = (prep == 0) ? 1 : prep;
        int z = (zero == 0) ? 1 : zero;
        int t = (trail == 0) ? 1 : trail;
        int e = (ex == 0) ? 1 : ex;
        int cyc = 0;
        logic last = 1'b1;
        logic [7:0] d;
        logic [7:0] tb;
        cfg_lpstate = 8'(lpx);
        cfg_hsprep  = 8'(prep);
        cfg_hszero  = 8'(zero);
        cfg_hstrail = 8'(trail);
        cfg_lpexit  = 8'(ex);
        step(self_req, 1'b0, 8'h00);
        chk(self_req ? "R2 idle before entry" : "R9 idle cycle before held entry",
            1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        for (int k = 0; k < l; k++) begin
            step(cyc == stray_at, 1'b0, 8'h00); cyc++;
            chk("R2 R4 LP-01 dwell", 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        end
        for (int k = 0; k < l; k++) begin
            step(cyc == stray_at, 1'b0, 8'h00); cyc++;
            chk("R2 R4 LP-00 dwell", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        end
        for (int k = 0; k < p + z; k++) begin
            step(cyc == stray_at, 1'b0, 8'h00); cyc++;
            chk("R3 R4 HS zero preamble", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
        end
        step(cyc == stray_at, 1'b0, 8'h00); cyc++;
        chk("R5 sync byte", 1'b0, 1'b0, 1'b1, 1'b0, 8'hB8, 1'b1);
        for (int k = 0; k < nb; k++) begin
            d = seed + 8'(k * 37);
            step(cyc == stray_at, 1'b1, d); cyc++;
            chk("R6 payload byte", 1'b0, 1'b0, 1'b1, 1'b1, d, 1'b1);
            last = d[7];
        end
        tb = {8{~last}};
        step(cyc == stray_at, 1'b0, 8'h00); cyc++;
        chk("R7 trail first cycle", 1'b0, 1'b0, 1'b1, 1'b1, tb, 1'b1);
        for (int k = 0; k < t; k++) begin
            step(cyc == stray_at, 1'b0, 8'h00); cyc++;
            chk("R7 R4 trail dwell", 1'b0, 1'b0, 1'b1, 1'b0, tb, 1'b1);
        end
        for (int k = 0; k < e; k++) begin
            step(k == exit_req_at, 1'b0, 8'h00);
            chk("R8 R4 LP-11 recovery", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        end
    endtask

    task automatic t_reset;
        tx_req = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset state", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        tx_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 state after reset release", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        idle_check(2, "R1 idle without request");
    endtask

    task automatic t_nominal;
        burst(3, 2, 7, 4, 6, 4, 1'b1, -1, -1, 8'h15);
        idle_check(3, "R8 idle after nominal burst");
    endtask

    task automatic t_zero_counts;
        burst(0, 0, 0, 0, 0, 0, 1'b1, -1, -1, 8'h00);
        idle_check(2, "R4 idle after minimum burst");
    endtask

    task automatic t_stray_requests;
        burst(2, 1, 3, 2, 3, 3, 1'b1, 1, -1, 8'h10);
        idle_check(5, "R10 request during LP-01 ignored");
        burst(2, 1, 3, 2, 3, 3, 1'b1, 9, -1, 8'h10);
        idle_check(5, "R10 request during payload ignored");
        burst(1, 1, 1, 2, 2, 1, 1'b1, 7, -1, 8'h7F);
        idle_check(5, "R10 request at trail start ignored");
    endtask

    task automatic t_exit_overlap;
        burst(2, 2, 2, 2, 5, 2, 1'b1, -1, 4, 8'h80);
        burst(1, 1, 1, 1, 2, 1, 1'b0, -1, -1, 8'h33);
        idle_check(3, "R9 single held request gives one burst");
        burst(2, 1, 1, 1, 4, 2, 1'b1, -1, 0, 8'h44);
        burst(3, 0, 2, 0, 1, 2, 1'b0, -1, 0, 8'hC1);
        burst(1, 1, 1, 1, 1, 0, 1'b0, -1, -1, 8'h00);
        idle_check(3, "R9 idle after chained bursts");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got a hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_nominal();
        t_zero_counts();
        t_stray_requests();
        t_exit_overlap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule